// File: doc/BRIEF.md
# Dual-Accumulator Saturating MAC Engine

This block is the arithmetic datapath of a 16-bit signal-processing core. Each clock it accepts one command: an opcode, an accumulator select, two 16-bit operands with a signedness bit for each, a shift source select, a signed shift amount and a 16-bit register value. It updates one of two 40-bit accumulators in that cycle.

A multiply widens each operand to 17 bits, so signed, unsigned and mixed products are all exact. The 34-bit product is added to, subtracted from, or loaded into the chosen accumulator through a 41-bit adder. The result clamps at the 40-bit rails instead of wrapping. A single-cycle barrel shifter moves either the chosen accumulator or the sign-extended register value by up to 16 places in either direction. A left shift that loses significant bits clamps in the same way.

Both accumulators are visible on the outputs. Each has a sticky clamp flag and a live guard-bit flag. Instruction decode, operand fetch and address generation happen upstream.

Top module: `dsp_mac_engine`

## Requirements
- R1: Operand `opnd_a` is widened to 17 bits by sign extension when `a_signed` is 1 and by zero extension when it is 0. `opnd_b` is widened the same way under `b_signed`. The product of the two widened values is exact.
- R2: Opcode 2 (load product) writes the product into the selected accumulator. `acc_sel` 0 selects A and 1 selects B.
- R3: Opcode 3 adds the product to the selected accumulator. Opcode 4 subtracts the product from it.
- R4: Only the selected accumulator changes. Opcode 0 and the unused codes 6 and 7 leave both accumulators and all flags unchanged.
- R5: Opcode 1 sets the selected accumulator to zero and clears that accumulator's sticky clamp flag.
- R6: A result above the positive limit is written as 40'h7F_FFFF_FFFF. A result below the negative limit is written as 40'h80_0000_0000.
- R7: `sat_a` and `sat_b` become 1 when their accumulator is clamped. They stay 1 until reset or opcode 1 on that accumulator.
- R8: `guard_a` and `guard_b` are 1 whenever bits 39 to 31 of their accumulator are not all equal, even when no clamp has occurred.
- R9: Opcode 5 shifts into the selected accumulator. `shift_amt` is a 5-bit two's complement value. A positive value shifts right arithmetically by up to 15 places. A negative value shifts left with zero fill by up to 16 places. A left shift that changes the value's meaning clamps per R6 and R7.
- R10: For opcode 5, `shift_src` 0 takes the selected accumulator as the source. `shift_src` 1 takes `reg_val` sign-extended to 40 bits.
- R11: While `rst_n` is low, both accumulators are zero and all four flags are 0.
- R12: Every operation completes in one clock. Its result is on the outputs after the rising edge that samples the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Command: 0 none, 1 clear, 2 load product, 3 add product, 4 subtract product, 5 shift |
| acc_sel | input | 1 | Destination accumulator: 0 A, 1 B |
| a_signed | input | 1 | Treat `opnd_a` as signed |
| b_signed | input | 1 | Treat `opnd_b` as signed |
| opnd_a | input | 16 | First multiplier operand |
| opnd_b | input | 16 | Second multiplier operand |
| shift_src | input | 1 | Shift source: 0 selected accumulator, 1 `reg_val` |
| shift_amt | input | 5 | Signed shift distance: positive right, negative left |
| reg_val | input | 16 | Register value used as a shift source |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| guard_a | output | 1 | A uses its guard bits |
| guard_b | output | 1 | B uses its guard bits |
| sat_a | output | 1 | Sticky clamp flag for A |
| sat_b | output | 1 | Sticky clamp flag for B |

## Verification
The bench builds the block with its default parameters: 16-bit operands, 40-bit accumulators and saturation enabled. With these values a single product of two most-negative operands is 2^30. One left shift by 8 then reaches the guard bits, and one more shift crosses the positive rail. A register value of 0x8000 shifted left twice by 16 crosses the negative rail. Both clamp values and the sticky flags can therefore be reached in a handful of commands instead of hundreds of accumulations.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_CLR   = 3'd1,
      OP_MPY   = 3'd2,
      OP_MAC   = 3'd3,
      OP_MSC   = 3'd4,
      OP_SHIFT = 3'd5
   } mac_op_e;
endpackage

// File: rtl/dsp_mul17.sv
module dsp_mul17 #(
   parameter int DATA_W = 16,
   localparam int EXT_W  = DATA_W + 1,
   localparam int PROD_W = 2 * EXT_W
) (
   input  logic [DATA_W-1:0]        a,
   input  logic [DATA_W-1:0]        b,
   input  logic                     a_sgn,
   input  logic                     b_sgn,
   output logic signed [PROD_W-1:0] prod
);
   logic signed [EXT_W-1:0] ax, bx;

   // extra top bit: copy of sign in signed mode, zero otherwise
   assign ax   = {a_sgn & a[DATA_W-1], a};
   assign bx   = {b_sgn & b[DATA_W-1], b};
   assign prod = ax * bx;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("dsp_mul17: DATA_W must be at least 2");
      end
   endgenerate
endmodule

// File: rtl/dsp_sat_add.sv
module dsp_sat_add #(
   parameter int ACC_W    = 40,
   parameter int PROD_W   = 34,
   parameter bit SATURATE = 1'b1,
   localparam int SUM_W   = ACC_W + 1
) (
   input  logic signed [ACC_W-1:0]  base,
   input  logic signed [PROD_W-1:0] prod,
   input  logic                     sub,
   output logic signed [ACC_W-1:0]  sum,
   output logic                     sat
);
   localparam logic [ACC_W-1:0] POS_RAIL = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_RAIL = {1'b1, {(ACC_W-1){1'b0}}};

   logic signed [SUM_W-1:0] wb, wp, raw;
   logic                    ovf;

   assign wb  = {base[ACC_W-1], base};
   assign wp  = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
   assign raw = sub ? (wb - wp) : (wb + wp);
   assign ovf = raw[SUM_W-1] ^ raw[SUM_W-2];

   generate
      if (PROD_W >= ACC_W) begin : g_bad_w
         $error("dsp_sat_add: accumulator must be wider than the product");
      end
      if (SATURATE) begin : g_clamp
         assign sum = ovf ? (raw[SUM_W-1] ? NEG_RAIL : POS_RAIL) : raw[ACC_W-1:0];
         assign sat = ovf;
      end else begin : g_wrap
         assign sum = raw[ACC_W-1:0];
         assign sat = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dsp_shift40.sv
module dsp_shift40 #(
   parameter int ACC_W    = 40,
   parameter int SH_W     = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [ACC_W-1:0] src,
   input  logic        [SH_W-1:0]  amt,
   output logic signed [ACC_W-1:0] res,
   output logic                    sat
);
   localparam logic [ACC_W-1:0] POS_RAIL = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_RAIL = {1'b1, {(ACC_W-1){1'b0}}};

   logic                    go_left, lost;
   logic [SH_W-1:0]         mag;
   logic signed [ACC_W-1:0] rsh, lsh, back;

   assign go_left = amt[SH_W-1];
   assign mag     = go_left ? (~amt + 1'b1) : amt;
   assign rsh     = src >>> mag;
   assign lsh     = src << mag;
   assign back    = lsh >>> mag;
   assign lost    = go_left && (back != src);

   generate
      if ((1 << (SH_W-1)) >= ACC_W) begin : g_bad_w
         $error("dsp_shift40: shift range exceeds accumulator width");
      end
      if (SATURATE) begin : g_clamp
         assign res = !go_left ? rsh : (lost ? (src[ACC_W-1] ? NEG_RAIL : POS_RAIL) : lsh);
         assign sat = lost;
      end else begin : g_wrap
         assign res = go_left ? lsh : rsh;
         assign sat = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine #(
   parameter int DATA_W    = 16,
   parameter int ACC_W     = 40,
   parameter int SHIFT_MAX = 16,
   parameter bit SATURATE  = 1'b1,
   localparam int SH_W     = $clog2(SHIFT_MAX) + 1,
   localparam int PROD_W   = 2 * (DATA_W + 1),
   localparam int GUARD_LO = 2 * DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op,
   input  logic              acc_sel,
   input  logic              a_signed,
   input  logic              b_signed,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              shift_src,
   input  logic [SH_W-1:0]   shift_amt,
   input  logic [DATA_W-1:0] reg_val,
   output logic [ACC_W-1:0]  acc_a,
   output logic [ACC_W-1:0]  acc_b,
   output logic              guard_a,
   output logic              guard_b,
   output logic              sat_a,
   output logic              sat_b
);
   import dsp_mac_pkg::*;

   localparam logic [ACC_W-1:0] POS_RAIL = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_RAIL = {1'b1, {(ACC_W-1){1'b0}}};

   mac_op_e                 opc;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  cur, base, add_sum, sh_src, sh_res;
   logic                    add_sat, sh_sat, is_sub;
   logic                    wr_en, clr_flag, set_flag;
   logic [ACC_W-1:0]        nxt_val;

   assign opc    = mac_op_e'(op);
   assign cur    = acc_sel ? acc_b : acc_a;
   assign base   = (opc == OP_MPY) ? '0 : cur;
   assign is_sub = (opc == OP_MSC);
   assign sh_src = shift_src ? {{(ACC_W-DATA_W){reg_val[DATA_W-1]}}, reg_val} : cur;

   dsp_mul17 #(.DATA_W(DATA_W)) u_mul (
      .a(opnd_a), .b(opnd_b), .a_sgn(a_signed), .b_sgn(b_signed), .prod(prod)
   );

   dsp_sat_add #(.ACC_W(ACC_W), .PROD_W(PROD_W), .SATURATE(SATURATE)) u_add (
      .base(base), .prod(prod), .sub(is_sub), .sum(add_sum), .sat(add_sat)
   );

   dsp_shift40 #(.ACC_W(ACC_W), .SH_W(SH_W), .SATURATE(SATURATE)) u_shf (
      .src(sh_src), .amt(shift_amt), .res(sh_res), .sat(sh_sat)
   );

   always_comb begin
      wr_en    = 1'b0;
      clr_flag = 1'b0;
      set_flag = 1'b0;
      nxt_val  = cur;
      case (opc)
         OP_CLR: begin
            wr_en = 1'b1; clr_flag = 1'b1; nxt_val = '0;
         end
         OP_MPY, OP_MAC, OP_MSC: begin
            wr_en = 1'b1; set_flag = add_sat; nxt_val = add_sum;
         end
         OP_SHIFT: begin
            wr_en = 1'b1; set_flag = sh_sat; nxt_val = sh_res;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_a <= '0;
         acc_b <= '0;
         sat_a <= 1'b0;
         sat_b <= 1'b0;
      end else if (wr_en) begin
         if (acc_sel) begin
            acc_b <= nxt_val;
            sat_b <= !clr_flag && (sat_b || set_flag);
         end else begin
            acc_a <= nxt_val;
            sat_a <= !clr_flag && (sat_a || set_flag);
         end
      end
   end

   assign guard_a = |acc_a[ACC_W-1:GUARD_LO] && !(&acc_a[ACC_W-1:GUARD_LO]);
   assign guard_b = |acc_b[ACC_W-1:GUARD_LO] && !(&acc_b[ACC_W-1:GUARD_LO]);

   generate
      if (GUARD_LO + 2 > ACC_W) begin : g_bad_w
         $error("dsp_mac_engine: no guard bits above the product");
      end
   endgenerate

   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd1 && !acc_sel) |=> (acc_a == '0 && !sat_a));
   // R4
   hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_sel) |=> $stable(acc_b));
   // R4
   hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel) |=> $stable(acc_a));
   // R7
   sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_b && !(op == 3'd1 && acc_sel)) |=> sat_b);
   // R6
   sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_a) |-> (acc_a == POS_RAIL || acc_a == NEG_RAIL));
   // R4
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd0 || op > 3'd5) |=> ($stable(sat_a) && $stable(sat_b)));
endmodule

// File: tb/tb_dsp_mac_engine.sv
module tb_dsp_mac_engine;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  op;
   logic        acc_sel, a_signed, b_signed, shift_src;
   logic [15:0] opnd_a, opnd_b, reg_val;
   logic [4:0]  shift_amt;
   logic [39:0] acc_a, acc_b;
   logic        guard_a, guard_b, sat_a, sat_b;

   int n_run = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dsp_mac_engine dut (
      .clk(clk), .rst_n(rst_n), .op(op), .acc_sel(acc_sel),
      .a_signed(a_signed), .b_signed(b_signed), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .shift_src(shift_src), .shift_amt(shift_amt), .reg_val(reg_val),
      .acc_a(acc_a), .acc_b(acc_b), .guard_a(guard_a), .guard_b(guard_b),
      .sat_a(sat_a), .sat_b(sat_b)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic        sel, asg, bsg, src;
      logic [4:0]  amt;
      logic [15:0] a, b, rv;
      logic [39:0] ea, eb;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h0003, 16'hFFFC, 16'h0000, 40'hFF_FFFF_FFF4, 40'h0},
      '{3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h0005, 16'h0006, 16'h0000, 40'h00_0000_0012, 40'h0},
      '{3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h0002, 16'h000A, 16'h0000, 40'hFF_FFFF_FFFE, 40'h0},
      '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'h00, 16'hFFFF, 16'hFFFF, 16'h0000, 40'hFF_FFFF_FFFE, 40'h00_FFFE_0001},
      '{3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 5'h00, 16'hFFFF, 16'hFFFF, 16'h0000, 40'hFF_FFFF_FFFE, 40'hFF_FFFF_0001},
      '{3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 5'h10, 16'h0000, 16'h0000, 16'h8000, 40'hFF_8000_0000, 40'hFF_FFFF_0001},
      '{3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 5'h04, 16'h0000, 16'h0000, 16'h0000, 40'hFF_F800_0000, 40'hFF_FFFF_0001},
      '{3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 5'h14, 16'h0000, 16'h0000, 16'h1234, 40'hFF_F800_0000, 40'h00_0123_4000},
      '{3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h0000, 16'h0000, 16'h0000, 40'h00_0000_0000, 40'h00_0123_4000},
      '{3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 5'h00, 16'h0007, 16'h0007, 16'h0000, 40'h00_0000_0000, 40'h00_0123_4000}
   };

   task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [2:0] o, input logic s, input logic as, input logic bs,
                      input logic src, input logic [4:0] amt,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] rv);
      @(negedge clk);
      op = o; acc_sel = s; a_signed = as; b_signed = bs; shift_src = src;
      shift_amt = amt; opnd_a = a; opnd_b = b; reg_val = rv;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_run++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; op = 3'd0; acc_sel = 1'b0; a_signed = 1'b0; b_signed = 1'b0;
      shift_src = 1'b0; shift_amt = '0; opnd_a = '0; opnd_b = '0; reg_val = '0;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11 acc_a", acc_a, 40'h0);
      chk("R11 acc_b", acc_b, 40'h0);
      chk("R11 flags", {36'h0, guard_a, guard_b, sat_a, sat_b}, 40'h0);
      @(negedge clk); rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R9 R10 R12 table walk
      foreach (VEC[i]) begin
         run(VEC[i].op, VEC[i].sel, VEC[i].asg, VEC[i].bsg, VEC[i].src, VEC[i].amt,
             VEC[i].a, VEC[i].b, VEC[i].rv);
         chk($sformatf("R12 vec%0d acc_a", i), acc_a, VEC[i].ea);
         chk($sformatf("R12 vec%0d acc_b", i), acc_b, VEC[i].eb);
      end

      // R4 unused code 7 leaves state alone
      run(3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h0001, 16'h0001, 16'h0);
      chk("R4 code7 acc_a", acc_a, 40'h0);
      chk("R4 code7 acc_b", acc_b, 40'h00_0123_4000);

      // R1 most-negative squared
      run(3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h8000, 16'h8000, 16'h0);
      chk("R1 min squared", acc_a, 40'h00_4000_0000);
      // R8 guard without clamp
      run(3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 5'h18, 16'h0, 16'h0, 16'h0);
      chk("R8 shift value", acc_a, 40'h40_0000_0000);
      chk("R8 guard_a", {39'h0, guard_a}, 40'h1);
      chk("R8 no sat_a", {39'h0, sat_a}, 40'h0);
      run(3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h8000, 16'h8000, 16'h0);
      chk("R3 mac", acc_a, 40'h40_4000_0000);
      // R9 R6 left shift clamps high
      run(3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 5'h1F, 16'h0, 16'h0, 16'h0);
      chk("R9 R6 shift clamp", acc_a, 40'h7F_FFFF_FFFF);
      chk("R7 sat_a set", {39'h0, sat_a}, 40'h1);
      run(3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h8000, 16'h8000, 16'h0);
      chk("R6 add clamp", acc_a, 40'h7F_FFFF_FFFF);
      run(3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, 16'h8000, 16'h8000, 16'h0);
      chk("R3 msc", acc_a, 40'h7F_BFFF_FFFF);
      chk("R7 sat_a sticky", {39'h0, sat_a}, 40'h1);

      // R10 R6 negative clamp on B
      run(3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 5'h10, 16'h0, 16'h0, 16'h8000);
      chk("R10 reg left16", acc_b, 40'hFF_8000_0000);
      run(3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 5'h10, 16'h0, 16'h0, 16'h0);
      chk("R6 neg clamp", acc_b, 40'h80_0000_0000);
      chk("R7 sat_b set", {39'h0, sat_b}, 40'h1);
      chk("R8 guard_b", {39'h0, guard_b}, 40'h1);
      run(3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 5'h0F, 16'h0, 16'h0, 16'h0);
      chk("R9 right15", acc_b, 40'hFF_FF00_0000);
      chk("R8 guard_b clear", {39'h0, guard_b}, 40'h0);

      // R5 clear B only
      run(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'h00, 16'h0, 16'h0, 16'h0);
      chk("R5 clr acc_b", acc_b, 40'h0);
      chk("R5 clr sat_b", {39'h0, sat_b}, 40'h0);
      chk("R4 acc_a kept", acc_a, 40'h7F_BFFF_FFFF);
      chk("R7 sat_a kept", {39'h0, sat_a}, 40'h1);

      // R1 R3 mixed signedness subtract
      run(3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 5'h00, 16'hFFFF, 16'h0002, 16'h0);
      chk("R1 mixed msc", acc_b, 40'hFF_FFFE_0002);

      // R11 reset mid-run
      @(negedge clk); rst_n = 1'b0; op = 3'd0;
      @(posedge clk); #1;
      chk("R11 rerst acc_a", acc_a, 40'h0);
      chk("R11 rerst flags", {36'h0, guard_a, guard_b, sat_a, sat_b}, 40'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule